// File: doc/BRIEF.md
# Reader Transceive Command Sequencer

This block runs one complete exchange with a contactless reader peripheral over a simple register-access port. The peripheral has a command register, an interrupt-request register, an error register, a FIFO with a level register, a bit-framing register and a control register. A host pulses `start` with a command code, a wait mask, the bytes to send and the framing settings. The sequencer then makes every register access the exchange needs and reports a single status code. It also returns the received bytes and the number of valid bits in the last byte.

The sequence has a fixed order. The sequencer first stops any running command. It then clears every pending interrupt request, flushes the FIFO and loads the transmit bytes. Next it programs the bit framing and issues the command. A transceive also gets its start-send bit set afterwards. The block then polls the interrupt register until the wait mask fires, the peripheral timer expires or a local cycle watchdog runs out. If the wait mask fired, the block decodes the error register in a fixed priority order, bounds and drains the FIFO, and reads the valid-bit count. When CRC checking is on, it can hand the received frame to an external CRC_A engine and compare that engine's result with the 2-byte trailer.

Top module: `rxt_sequencer`

## Requirements
- R1: After `start` is accepted, the register writes occur in this order:
  1. 0x00 to the command register.
  2. The value just read from the interrupt register, ORed with 0x7F, back to the interrupt register.
  3. 0x80 to the FIFO level register.
  4. `tx_len` FIFO data writes, starting with byte 0 (`tx_data[7:0]`).
  5. The bit-framing write.
  6. The command code to the command register.
- R2: The bit-framing byte written before the command equals `{1'b0, rx_align, 1'b0, tx_last_bits}`, that is (rx_align << 4) + tx_last_bits.
- R3: Only when the command code is 0xC (transceive), after the command write the framing register is read and written back with bit 7 (start-send) set. Any other code produces no write after the command write.
- R4: Polling reads the interrupt register (timer-expired flag is bit 0). It proceeds to error checking as soon as the read value ANDed with `wait_mask` is nonzero. Otherwise, a set bit 0 ends the exchange with status 1 (timeout). The mask test takes precedence over bit 0.
- R5: If neither condition appears, polling is abandoned with status 1 once `WDOG_LIMIT` cycles have been spent polling.
- R6: The error register is classified in priority order:
  - bit 0 (protocol) gives status 2;
  - otherwise bit 1 (parity) or bit 4 (FIFO overflow) gives status 3;
  - otherwise bit 3 (collision) gives status 4.
- R7: The FIFO level is the low 7 bits of the level register.
  - If it exceeds `rx_cap`, the exchange ends with status 5, no FIFO data is read and `rx_len` stays 0.
  - Otherwise exactly that many bytes are read into `rx_data`, the first received byte in bits [7:0].
- R8: `rx_bits` takes the low three bits of the control register, which is read after the FIFO is drained.
- R9: With `crc_check` set, a 1-byte reply whose `rx_bits` is 4 ends with status 6 (NAK).
- R10: With `crc_check` set, any other reply shorter than 2 bytes, or one with `rx_bits` not 0, ends with status 7.
- R11: Otherwise, with `crc_check` set, `crc_req` is raised with `crc_len` = `rx_len` - 2. The exchange ends with status 0 when `crc_val[7:0]` equals byte `rx_len`-2 and `crc_val[15:8]` equals byte `rx_len`-1; otherwise it ends with status 8. Without `crc_check` a completed exchange ends with status 0.
- R12: After reset `busy`, `done` and `status` are 0. `busy` is high from an accepted `start` until the cycle after `done`. `done` is a one-cycle pulse. A `start` while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an exchange (accepted only when idle) |
| cmd_code | input | 4 | Command to issue; 0xC is transceive |
| wait_mask | input | 8 | Interrupt bits that end polling successfully |
| tx_data | input | MAX_TX*8 | Transmit bytes, byte 0 in the low bits |
| tx_len | input | $clog2(MAX_TX+1) | Number of transmit bytes |
| tx_last_bits | input | 3 | Valid bits in the last transmitted byte |
| rx_align | input | 3 | Bit position of the first received bit |
| rx_cap | input | $clog2(MAX_RX+1) | Receive capacity in bytes |
| crc_check | input | 1 | Enable reply validation and CRC compare |
| bus_req | output | 1 | Register access request, held until `bus_ack` |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 8 | Write data |
| bus_ack | input | 1 | Access complete; read data valid |
| bus_rdata | input | 8 | Read data |
| crc_req | output | 1 | Request a CRC_A over the first `crc_len` received bytes |
| crc_len | output | $clog2(MAX_RX+1) | Bytes covered by the CRC |
| crc_ack | input | 1 | CRC result valid |
| crc_val | input | 16 | CRC result, low byte in [7:0] |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 4 | Result code of the last exchange |
| rx_data | output | MAX_RX*8 | Received bytes, byte 0 in the low bits |
| rx_len | output | $clog2(MAX_RX+1) | Number of received bytes |
| rx_bits | output | 3 | Valid bits in the last received byte |

## Verification
The bench sets several error bits at once to test the error priority. A design that tested collision or parity before protocol would report the wrong one of statuses 2, 3 and 4. One poll response carries both a wait-mask bit and the timer bit, so a design that looked at the timer first would report a timeout on a good exchange. The bench also sends a 1-byte reply with four valid bits, a short reply, a partial final byte and a bad trailer. A design with the NAK, short-frame and CRC rules in the wrong order would return 7 where 6 is expected, or 8 where 7 is expected. Finally the bench compares the full write log of a transceive against the required order. That log exposes an irq-clear write that drops the bits it read, a missing or misplaced start-send write, and a second `start` accepted while busy.

// File: rtl/rxt_pkg.sv
package rxt_pkg;

   typedef enum logic [3:0] {
      ST_OK       = 4'd0,
      ST_TIMEOUT  = 4'd1,
      ST_PROTO    = 4'd2,
      ST_IO       = 4'd3,
      ST_COLL     = 4'd4,
      ST_NOMEM    = 4'd5,
      ST_NAK      = 4'd6,
      ST_SHORT    = 4'd7,
      ST_CRC_BAD  = 4'd8
   } rxt_status_e;

   typedef enum logic [4:0] {
      PH_IDLE,
      PH_STOP,
      PH_IRQ_RD,
      PH_IRQ_WR,
      PH_FLUSH,
      PH_LOAD,
      PH_FRAME,
      PH_CMD,
      PH_SS_RD,
      PH_SS_WR,
      PH_POLL,
      PH_ERR_RD,
      PH_LVL_RD,
      PH_FIFO_RD,
      PH_CTL_RD,
      PH_CRC,
      PH_FIN
   } rxt_phase_e;

   localparam int unsigned IRQ_TIMER_BIT  = 0;
   localparam int unsigned ERR_PROTO_BIT  = 0;
   localparam int unsigned ERR_PARITY_BIT = 1;
   localparam int unsigned ERR_COLL_BIT   = 3;
   localparam int unsigned ERR_OVFL_BIT   = 4;

   localparam logic [7:0] IRQ_CLEAR_ALL = 8'h7F;
   localparam logic [7:0] FIFO_FLUSH    = 8'h80;
   localparam logic [7:0] START_SEND    = 8'h80;
   localparam logic [2:0] NAK_BITS      = 3'd4;

endpackage

// File: rtl/rxt_err_class.sv
module rxt_err_class
   import rxt_pkg::*;
(
   input  logic [7:0]  err_byte,
   output rxt_status_e code
);

   logic hit_proto;
   logic hit_io;
   logic hit_coll;

   always_comb begin
      hit_proto = err_byte[ERR_PROTO_BIT];
      hit_io    = err_byte[ERR_PARITY_BIT] | err_byte[ERR_OVFL_BIT];
      hit_coll  = err_byte[ERR_COLL_BIT];
      if (hit_proto)     code = ST_PROTO;
      else if (hit_io)   code = ST_IO;
      else if (hit_coll) code = ST_COLL;
      else               code = ST_OK;
   end

endmodule

// File: rtl/rxt_wdog.sv
module rxt_wdog #(
   parameter int unsigned LIMIT = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);

   localparam int unsigned CW = $clog2(LIMIT + 1);

   generate
      if (LIMIT < 2) begin : g_bad_limit
         $error("rxt_wdog: LIMIT must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (!run)                      cnt_q <= '0;
      else if (cnt_q != CW'(LIMIT))       cnt_q <= cnt_q + 1'b1;
   end

   assign expired = (cnt_q == CW'(LIMIT));

   // R5
   wdog_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q <= CW'(LIMIT)));

endmodule

// File: rtl/rxt_rx_store.sv
module rxt_rx_store #(
   parameter int unsigned DEPTH = 9
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         clr,
   input  logic                         we,
   input  logic [7:0]                   wdata,
   output logic [DEPTH*8-1:0]           data,
   output logic [$clog2(DEPTH+1)-1:0]   count
);

   localparam int unsigned CW = $clog2(DEPTH + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               cnt_q <= '0;
      else if (clr)                             cnt_q <= '0;
      else if (we && cnt_q != CW'(DEPTH))       cnt_q <= cnt_q + 1'b1;
   end

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         logic [7:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          slot_q <= '0;
            else if (clr)                        slot_q <= '0;
            else if (we && cnt_q == CW'(g))      slot_q <= wdata;
         end
         assign data[g*8 +: 8] = slot_q;
      end
   endgenerate

   assign count = cnt_q;

   // R7
   store_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q <= CW'(DEPTH)));

endmodule

// File: rtl/rxt_sequencer.sv
module rxt_sequencer
   import rxt_pkg::*;
#(
   parameter int unsigned MAX_TX     = 8,
   parameter int unsigned MAX_RX     = 9,
   parameter int unsigned WDOG_LIMIT = 1250000,
   parameter int unsigned ADDR_W     = 6,
   parameter logic [5:0]  A_CMD      = 6'h01,
   parameter logic [5:0]  A_IRQ      = 6'h04,
   parameter logic [5:0]  A_ERR      = 6'h06,
   parameter logic [5:0]  A_FIFO     = 6'h09,
   parameter logic [5:0]  A_LEVEL    = 6'h0A,
   parameter logic [5:0]  A_CTRL     = 6'h0C,
   parameter logic [5:0]  A_FRAME    = 6'h0D,
   parameter logic [3:0]  CMD_IDLE   = 4'h0,
   parameter logic [3:0]  CMD_TRX    = 4'hC
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [3:0]                    cmd_code,
   input  logic [7:0]                    wait_mask,
   input  logic [MAX_TX*8-1:0]           tx_data,
   input  logic [$clog2(MAX_TX+1)-1:0]   tx_len,
   input  logic [2:0]                    tx_last_bits,
   input  logic [2:0]                    rx_align,
   input  logic [$clog2(MAX_RX+1)-1:0]   rx_cap,
   input  logic                          crc_check,
   output logic                          bus_req,
   output logic                          bus_we,
   output logic [ADDR_W-1:0]             bus_addr,
   output logic [7:0]                    bus_wdata,
   input  logic                          bus_ack,
   input  logic [7:0]                    bus_rdata,
   output logic                          crc_req,
   output logic [$clog2(MAX_RX+1)-1:0]   crc_len,
   input  logic                          crc_ack,
   input  logic [15:0]                   crc_val,
   output logic                          busy,
   output logic                          done,
   output logic [3:0]                    status,
   output logic [MAX_RX*8-1:0]           rx_data,
   output logic [$clog2(MAX_RX+1)-1:0]   rx_len,
   output logic [2:0]                    rx_bits
);

   localparam int unsigned TXL_W = $clog2(MAX_TX + 1);
   localparam int unsigned RXL_W = $clog2(MAX_RX + 1);
   localparam int unsigned IDX_W = (TXL_W > RXL_W) ? TXL_W : RXL_W;

   generate
      if (MAX_RX < 2 || MAX_RX > 127) begin : g_bad_rx
         $error("rxt_sequencer: MAX_RX must lie in 2..127");
      end
      if (MAX_TX < 1 || MAX_TX > 64) begin : g_bad_tx
         $error("rxt_sequencer: MAX_TX must lie in 1..64");
      end
      if (ADDR_W < 6) begin : g_bad_addr
         $error("rxt_sequencer: ADDR_W must be at least 6");
      end
   endgenerate

   rxt_phase_e             ph_q;
   rxt_status_e            st_q;
   rxt_status_e            err_code;
   logic [3:0]             cmd_q;
   logic [7:0]             mask_q;
   logic [MAX_TX*8-1:0]    tx_q;
   logic [TXL_W-1:0]       txlen_q;
   logic [7:0]             frame_q;
   logic [RXL_W-1:0]       cap_q;
   logic                   crc_en_q;
   logic [RXL_W-1:0]       level_q;
   logic [IDX_W-1:0]       idx_q;
   logic [7:0]             tmp_q;
   logic [2:0]             bits_q;
   logic                   wd_expired;
   logic                   store_clr;
   logic                   store_we;
   logic [7:0]             lvl_ext;
   logic [7:0]             cap_ext;
   logic [7:0]             crc_lo_byte;
   logic [7:0]             crc_hi_byte;

   // sub-blocks
   rxt_err_class u_err (
      .err_byte (bus_rdata),
      .code     (err_code)
   );

   rxt_wdog #(.LIMIT(WDOG_LIMIT)) u_wdog (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ph_q == PH_POLL),
      .expired (wd_expired)
   );

   assign store_clr = (ph_q == PH_IDLE) && start;
   assign store_we  = (ph_q == PH_FIFO_RD) && bus_ack;

   rxt_rx_store #(.DEPTH(MAX_RX)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (store_clr),
      .we    (store_we),
      .wdata (bus_rdata),
      .data  (rx_data),
      .count (rx_len)
   );

   // bus drive, decoded from the phase
   always_comb begin
      bus_req   = 1'b1;
      bus_we    = 1'b0;
      bus_addr  = '0;
      bus_wdata = '0;
      unique case (ph_q)
         PH_STOP:    begin bus_we = 1'b1; bus_addr = ADDR_W'(A_CMD);   bus_wdata = {4'h0, CMD_IDLE}; end
         PH_IRQ_RD:  begin bus_addr = ADDR_W'(A_IRQ); end
         PH_IRQ_WR:  begin bus_we = 1'b1; bus_addr = ADDR_W'(A_IRQ);   bus_wdata = tmp_q | IRQ_CLEAR_ALL; end
         PH_FLUSH:   begin bus_we = 1'b1; bus_addr = ADDR_W'(A_LEVEL); bus_wdata = FIFO_FLUSH; end
         PH_LOAD:    begin bus_we = 1'b1; bus_addr = ADDR_W'(A_FIFO);  bus_wdata = tx_q[idx_q*8 +: 8]; end
         PH_FRAME:   begin bus_we = 1'b1; bus_addr = ADDR_W'(A_FRAME); bus_wdata = frame_q; end
         PH_CMD:     begin bus_we = 1'b1; bus_addr = ADDR_W'(A_CMD);   bus_wdata = {4'h0, cmd_q}; end
         PH_SS_RD:   begin bus_addr = ADDR_W'(A_FRAME); end
         PH_SS_WR:   begin bus_we = 1'b1; bus_addr = ADDR_W'(A_FRAME); bus_wdata = tmp_q | START_SEND; end
         PH_POLL:    begin bus_addr = ADDR_W'(A_IRQ); end
         PH_ERR_RD:  begin bus_addr = ADDR_W'(A_ERR); end
         PH_LVL_RD:  begin bus_addr = ADDR_W'(A_LEVEL); end
         PH_FIFO_RD: begin bus_addr = ADDR_W'(A_FIFO); end
         PH_CTL_RD:  begin bus_addr = ADDR_W'(A_CTRL); end
         default:    begin bus_req = 1'b0; end
      endcase
   end

   assign lvl_ext     = {1'b0, bus_rdata[6:0]};
   assign cap_ext     = 8'(cap_q);
   assign crc_len     = level_q - RXL_W'(2);
   assign crc_lo_byte = rx_data[crc_len*8 +: 8];
   assign crc_hi_byte = rx_data[(crc_len+RXL_W'(1))*8 +: 8];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q     <= PH_IDLE;
         st_q     <= ST_OK;
         cmd_q    <= '0;
         mask_q   <= '0;
         tx_q     <= '0;
         txlen_q  <= '0;
         frame_q  <= '0;
         cap_q    <= '0;
         crc_en_q <= 1'b0;
         level_q  <= '0;
         idx_q    <= '0;
         tmp_q    <= '0;
         bits_q   <= '0;
      end else begin
         unique case (ph_q)
            PH_IDLE: if (start) begin
               cmd_q    <= cmd_code;
               mask_q   <= wait_mask;
               tx_q     <= tx_data;
               txlen_q  <= (32'(tx_len) > MAX_TX) ? TXL_W'(MAX_TX) : tx_len;
               frame_q  <= {1'b0, rx_align, 1'b0, tx_last_bits};
               cap_q    <= (32'(rx_cap) > MAX_RX) ? RXL_W'(MAX_RX) : rx_cap;
               crc_en_q <= crc_check;
               level_q  <= '0;
               bits_q   <= '0;
               ph_q     <= PH_STOP;
            end
            PH_STOP:   if (bus_ack) ph_q <= PH_IRQ_RD;
            PH_IRQ_RD: if (bus_ack) begin tmp_q <= bus_rdata; ph_q <= PH_IRQ_WR; end
            PH_IRQ_WR: if (bus_ack) ph_q <= PH_FLUSH;
            PH_FLUSH:  if (bus_ack) begin
               idx_q <= '0;
               ph_q  <= (txlen_q == '0) ? PH_FRAME : PH_LOAD;
            end
            PH_LOAD:   if (bus_ack) begin
               idx_q <= idx_q + 1'b1;
               if (idx_q + 1'b1 == IDX_W'(txlen_q)) ph_q <= PH_FRAME;
            end
            PH_FRAME:  if (bus_ack) ph_q <= PH_CMD;
            PH_CMD:    if (bus_ack) ph_q <= (cmd_q == CMD_TRX) ? PH_SS_RD : PH_POLL;
            PH_SS_RD:  if (bus_ack) begin tmp_q <= bus_rdata; ph_q <= PH_SS_WR; end
            PH_SS_WR:  if (bus_ack) ph_q <= PH_POLL;
            PH_POLL:   if (bus_ack) begin
               if ((bus_rdata & mask_q) != 8'h00) ph_q <= PH_ERR_RD;
               else if (bus_rdata[IRQ_TIMER_BIT] || wd_expired) begin
                  st_q <= ST_TIMEOUT; ph_q <= PH_FIN;
               end
            end
            PH_ERR_RD: if (bus_ack) begin
               if (err_code != ST_OK) begin st_q <= err_code; ph_q <= PH_FIN; end
               else ph_q <= PH_LVL_RD;
            end
            PH_LVL_RD: if (bus_ack) begin
               if (lvl_ext > cap_ext) begin
                  st_q <= ST_NOMEM; ph_q <= PH_FIN;
               end else begin
                  level_q <= RXL_W'(lvl_ext);
                  idx_q   <= '0;
                  ph_q    <= (lvl_ext == 8'h00) ? PH_CTL_RD : PH_FIFO_RD;
               end
            end
            PH_FIFO_RD: if (bus_ack) begin
               idx_q <= idx_q + 1'b1;
               if (idx_q + 1'b1 == IDX_W'(level_q)) ph_q <= PH_CTL_RD;
            end
            PH_CTL_RD: if (bus_ack) begin
               bits_q <= bus_rdata[2:0];
               if (!crc_en_q) begin
                  st_q <= ST_OK; ph_q <= PH_FIN;
               end else if (level_q == RXL_W'(1) && bus_rdata[2:0] == NAK_BITS) begin
                  st_q <= ST_NAK; ph_q <= PH_FIN;
               end else if (level_q < RXL_W'(2) || bus_rdata[2:0] != 3'd0) begin
                  st_q <= ST_SHORT; ph_q <= PH_FIN;
               end else begin
                  ph_q <= PH_CRC;
               end
            end
            PH_CRC: if (crc_ack) begin
               st_q <= ({crc_hi_byte, crc_lo_byte} == crc_val) ? ST_OK : ST_CRC_BAD;
               ph_q <= PH_FIN;
            end
            PH_FIN:  ph_q <= PH_IDLE;
            default: ph_q <= PH_IDLE;
         endcase
      end
   end

   assign crc_req = (ph_q == PH_CRC);
   assign busy    = (ph_q != PH_IDLE);
   assign done    = (ph_q == PH_FIN);
   assign status  = st_q;
   assign rx_bits = bits_q;

   // R12
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R1
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

   // R7
   nomem_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == ST_NOMEM) |-> (rx_len == '0));

   // R11
   crc_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      crc_req |-> ((crc_len + RXL_W'(2)) == rx_len));

endmodule

// File: tb/rxt_sequencer_tb.sv
module rxt_sequencer_tb;
   import rxt_pkg::*;

   localparam int unsigned MAX_TX = 8;
   localparam int unsigned MAX_RX = 9;
   localparam int unsigned WDL    = 300;
   localparam int unsigned NV     = 16;

   // cmd, mask, irq, err, lvl, cap, ctl, crc_en, crc_good, expected status, pad
   localparam logic [63:0] VEC [NV] = '{
      {4'hC, 8'h30, 8'h20, 8'h00, 8'd3, 8'd9, 8'h00, 1'b0, 1'b0, 4'd0, 6'd0},
      {4'hC, 8'h30, 8'h01, 8'h00, 8'd3, 8'd9, 8'h00, 1'b0, 1'b0, 4'd1, 6'd0},
      {4'hC, 8'h30, 8'h21, 8'h00, 8'd2, 8'd9, 8'h00, 1'b0, 1'b0, 4'd0, 6'd0},
      {4'hC, 8'h30, 8'h20, 8'h1B, 8'd3, 8'd9, 8'h00, 1'b0, 1'b0, 4'd2, 6'd0},
      {4'hC, 8'h30, 8'h20, 8'h1A, 8'd3, 8'd9, 8'h00, 1'b0, 1'b0, 4'd3, 6'd0},
      {4'hC, 8'h30, 8'h20, 8'h08, 8'd3, 8'd9, 8'h00, 1'b0, 1'b0, 4'd4, 6'd0},
      {4'hC, 8'h30, 8'h20, 8'h10, 8'd3, 8'd9, 8'h00, 1'b0, 1'b0, 4'd3, 6'd0},
      {4'hC, 8'h30, 8'h20, 8'h00, 8'd5, 8'd4, 8'h00, 1'b0, 1'b0, 4'd5, 6'd0},
      {4'hC, 8'h30, 8'h20, 8'h00, 8'd1, 8'd9, 8'h04, 1'b1, 1'b0, 4'd6, 6'd0},
      {4'hC, 8'h30, 8'h20, 8'h00, 8'd1, 8'd9, 8'h00, 1'b1, 1'b0, 4'd7, 6'd0},
      {4'hC, 8'h30, 8'h20, 8'h00, 8'd3, 8'd9, 8'h02, 1'b1, 1'b1, 4'd7, 6'd0},
      {4'hC, 8'h30, 8'h20, 8'h00, 8'd4, 8'd9, 8'h00, 1'b1, 1'b1, 4'd0, 6'd0},
      {4'hC, 8'h30, 8'h20, 8'h00, 8'd4, 8'd9, 8'h00, 1'b1, 1'b0, 4'd8, 6'd0},
      {4'h3, 8'h10, 8'h10, 8'h00, 8'd0, 8'd9, 8'h05, 1'b0, 1'b0, 4'd0, 6'd0},
      {4'hC, 8'h30, 8'h20, 8'h00, 8'd1, 8'd9, 8'h04, 1'b0, 1'b0, 4'd0, 6'd0},
      {4'hC, 8'h30, 8'h20, 8'h00, 8'd9, 8'd9, 8'h03, 1'b0, 1'b0, 4'd0, 6'd0}
   };

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [3:0]         cmd_code = '0;
   logic [7:0]         wait_mask = '0;
   logic [MAX_TX*8-1:0] tx_data = '0;
   logic [3:0]         tx_len = '0;
   logic [2:0]         tx_last_bits = '0;
   logic [2:0]         rx_align = '0;
   logic [3:0]         rx_cap = '0;
   logic               crc_check = 1'b0;
   logic               bus_req, bus_we;
   logic [5:0]         bus_addr;
   logic [7:0]         bus_wdata;
   logic               bus_ack;
   logic [7:0]         bus_rdata;
   logic               crc_req;
   logic [3:0]         crc_len;
   logic               crc_ack;
   logic [15:0]        crc_val;
   logic               busy, done;
   logic [3:0]         status;
   logic [MAX_RX*8-1:0] rx_data;
   logic [3:0]         rx_len;
   logic [2:0]         rx_bits;

   // peripheral model settings, driven by the test sequence
   logic               clear_model = 1'b0;
   logic [7:0]         irq_final = '0;
   logic [7:0]         err_v = '0;
   logic [7:0]         lvl_v = '0;
   logic [7:0]         ctl_v = '0;
   logic               crc_good = 1'b0;
   logic [7:0]         rx_src [16];

   // peripheral model state
   logic [5:0]         log_a [64];
   logic [7:0]         log_d [64];
   int                 log_n;
   int                 poll_n;
   int                 rd_i;
   logic               cmd_seen;
   logic [7:0]         fr_reg;

   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;
   int cycles;

   always #10 clk = ~clk;

   rxt_sequencer #(.MAX_TX(MAX_TX), .MAX_RX(MAX_RX), .WDOG_LIMIT(WDL)) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .cmd_code(cmd_code),
      .wait_mask(wait_mask), .tx_data(tx_data), .tx_len(tx_len),
      .tx_last_bits(tx_last_bits), .rx_align(rx_align), .rx_cap(rx_cap),
      .crc_check(crc_check), .bus_req(bus_req), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
      .bus_rdata(bus_rdata), .crc_req(crc_req), .crc_len(crc_len),
      .crc_ack(crc_ack), .crc_val(crc_val), .busy(busy), .done(done),
      .status(status), .rx_data(rx_data), .rx_len(rx_len), .rx_bits(rx_bits)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n || clear_model) begin
         bus_ack   <= 1'b0;
         bus_rdata <= '0;
         crc_ack   <= 1'b0;
         crc_val   <= '0;
         log_n     <= 0;
         poll_n    <= 0;
         rd_i      <= 0;
         cmd_seen  <= 1'b0;
         fr_reg    <= '0;
      end else begin
         bus_ack <= 1'b0;
         crc_ack <= crc_req && !crc_ack;
         crc_val <= crc_good ? {rx_src[lvl_v-1], rx_src[lvl_v-2]} : 16'hDEAD;
         if (bus_req && !bus_ack) begin
            bus_ack <= 1'b1;
            if (bus_we) begin
               if (log_n < 64) begin
                  log_a[log_n] <= bus_addr;
                  log_d[log_n] <= bus_wdata;
               end
               log_n <= log_n + 1;
               if (bus_addr == 6'h0D) fr_reg <= bus_wdata;
               if (bus_addr == 6'h01) cmd_seen <= (bus_wdata[3:0] != 4'h0);
            end else begin
               case (bus_addr)
                  6'h04: begin
                     if (cmd_seen) begin
                        poll_n    <= poll_n + 1;
                        bus_rdata <= (poll_n >= 2) ? irq_final : 8'h00;
                     end else begin
                        bus_rdata <= 8'h80;
                     end
                  end
                  6'h06: bus_rdata <= err_v;
                  6'h0A: bus_rdata <= lvl_v;
                  6'h09: begin bus_rdata <= rx_src[rd_i[3:0]]; rd_i <= rd_i + 1; end
                  6'h0C: bus_rdata <= ctl_v;
                  6'h0D: bus_rdata <= fr_reg;
                  default: bus_rdata <= 8'h00;
               endcase
            end
         end
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic run_x(input logic [3:0] c, input logic [7:0] m, input logic [3:0] tl,
                        input logic [3:0] cap, input logic ce, input bit poke);
      @(negedge clk) clear_model = 1'b1;
      @(negedge clk) clear_model = 1'b0;
      cmd_code = c; wait_mask = m; tx_len = tl; rx_cap = cap; crc_check = ce;
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      cycles = 1;
      if (poke) begin
         repeat (6) @(negedge clk);
         cycles += 6;
         cmd_code = 4'h3; start = 1'b1;
         @(negedge clk) start = 1'b0;
         cycles++;
      end
      while (!done && cycles < 20000) begin
         @(negedge clk);
         cycles++;
      end
   endtask

   task automatic chk_log(input int k, input logic [5:0] a, input logic [7:0] d, input string req);
      chk(log_a[k] == a && log_d[k] == d, req, {log_a[k], log_d[k]}, {a, d});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run did not complete");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) rx_src[i] = '0;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(!busy && !done && status == 4'd0 && !bus_req && rx_len == 0, "R12 reset",
          {busy, done, status, bus_req}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // vector table
      for (int v = 0; v < NV; v++) begin
         logic [63:0] w;
         int lv;
         int exp_st;
         int exp_len;
         bit reached;
         w = VEC[v];
         irq_final = w[51:44]; err_v = w[43:36]; lvl_v = w[35:28];
         ctl_v = w[19:12]; crc_good = w[10];
         lv = int'(w[35:28]);
         exp_st = int'(w[9:6]);
         for (int i = 0; i < 16; i++) rx_src[i] = 8'(8'h11 * (i + 1)) ^ 8'(v);
         tx_data = 64'h0123_4567_89AB_CDEF;
         tx_last_bits = 3'd7; rx_align = 3'd0;
         run_x(w[63:60], w[59:52], 4'd2, w[23:20], w[11], 1'b0);
         // R4 R6 R7 R9 R10 R11
         chk(status == 4'(exp_st), $sformatf("R4/R6/R7/R9/R10/R11 status v%0d", v), status, exp_st);
         reached = (exp_st == 0 || exp_st >= 6);
         exp_len = reached ? lv : 0;
         // R7 length
         chk(rx_len == 4'(exp_len), $sformatf("R7 rx_len v%0d", v), rx_len, exp_len);
         if (reached) begin
            // R8 valid bits
            chk(rx_bits == w[14:12], $sformatf("R8 rx_bits v%0d", v), rx_bits, w[14:12]);
            for (int i = 0; i < lv; i++)
               chk(rx_data[i*8 +: 8] == rx_src[i], $sformatf("R7 byte %0d v%0d", i, v),
                   rx_data[i*8 +: 8], rx_src[i]);
         end
         // R1 command written
         chk_log(6, 6'h01, {4'h0, w[63:60]}, $sformatf("R1 cmd write v%0d", v));
      end

      // directed: full write order of a transceive, with a start while busy
      irq_final = 8'h20; err_v = 8'h00; lvl_v = 8'd0; ctl_v = 8'h00; crc_good = 1'b0;
      tx_data = 64'h0; tx_data[23:0] = 24'h5520_93;
      tx_last_bits = 3'd3; rx_align = 3'd3;
      run_x(4'hC, 8'h30, 4'd3, 4'd9, 1'b0, 1'b1);
      chk(status == 4'd0, "R3 transceive status", status, 0);
      chk(log_n == 9, "R12 start while busy ignored / R3 write count", log_n, 9);
      chk_log(0, 6'h01, 8'h00, "R1 stop");
      chk_log(1, 6'h04, 8'hFF, "R1 irq clear");
      chk_log(2, 6'h0A, 8'h80, "R1 flush");
      chk_log(3, 6'h09, 8'h93, "R1 tx0");
      chk_log(4, 6'h09, 8'h20, "R1 tx1");
      chk_log(5, 6'h09, 8'h55, "R1 tx2");
      chk_log(6, 6'h0D, 8'h33, "R2 framing");
      chk_log(7, 6'h01, 8'h0C, "R1 command");
      chk_log(8, 6'h0D, 8'hB3, "R3 start-send");
      @(negedge clk);
      chk(!busy && !done, "R12 done one cycle", {busy, done}, 0);

      // directed: non-transceive, no transmit bytes, no start-send
      tx_last_bits = 3'd0; rx_align = 3'd5; irq_final = 8'h10;
      run_x(4'h3, 8'h10, 4'd0, 4'd9, 1'b0, 1'b0);
      chk(log_n == 5, "R3 no start-send write count", log_n, 5);
      chk_log(3, 6'h0D, 8'h50, "R2 framing align");
      chk_log(4, 6'h01, 8'h03, "R3 last write is command");

      // directed: watchdog, interrupt register never reports anything
      irq_final = 8'h00;
      run_x(4'hC, 8'h30, 4'd1, 4'd9, 1'b0, 1'b0);
      chk(status == 4'd1, "R5 watchdog status", status, 1);
      chk(cycles >= int'(WDL) && cycles < int'(WDL) + 60, "R5 watchdog time", cycles, WDL);

      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule